// File: doc/BRIEF.md
# Time-of-Day Counter with Fine Frequency Trim

This block keeps a running time of day for a precision time protocol engine. The time is held as three 32-bit fields: whole seconds, nanoseconds within the second, and a residue of sub-nanosecond fractions in units of 2^-32 ns. On every enabled clock cycle the value advances by a fixed nominal period of 12.5 ns plus or minus a trim. The trim comes from a sign-magnitude adjust word, so software can tune the rate of the clock without touching the stored time.

Software reaches the block through simple register strobes. It can load each time field, load the adjust word, and stop or start the counter with a halt bit. It reads the full time through a snapshot. A read of the residue field copies the nanoseconds and seconds fields into shadow registers, and later reads of those two addresses return the shadow copies. The three words therefore always describe one instant.

Top module: `tod_counter`

## Requirements
- R1: After reset the seconds, nanoseconds, residue, adjust word and both shadow copies read as 0, and the control word reads 1 (halted).
- R2: While the halt bit is 1, none of the three time fields changes, except through an explicit write.
- R3: While running with an adjust word of 0, each cycle adds 0x80000000 to the residue and 12 ns plus the residue carry to the nanoseconds, so 10 cycles from zero give 125 ns and residue 0.
- R4: With adjust bit 31 equal to 0, the per-cycle step in 2^-32 ns units is 0xC80000000 plus bits 30:0 of the adjust word.
- R5: With adjust bit 31 equal to 1, the per-cycle step is 0xC80000000 minus bits 30:0 of the adjust word.
- R6: When nanoseconds plus the step reaches 1,000,000,000, the block subtracts 1,000,000,000 and adds one to seconds in the same cycle.
- R7: Seconds wrap from 0xFFFFFFFF to 0 without any other effect.
- R8: A read of the residue returns its current value and copies nanoseconds and seconds into shadow registers. Reads of the nanoseconds and seconds addresses return the shadow copies. Read data appears on rdata_o one cycle after the read strobe and holds until the next read.
- R9: A write to a time field loads it at the next edge. In that cycle no time field advances.
- R10: The register map is: address 0 residue, 1 nanoseconds, 2 seconds, 3 adjust word, 4 control (bit 0 = halt). Addresses 5 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one time step per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |

## Verification
A write takes effect at the clock edge where its strobe is sampled, and the tick in that same cycle uses the control and adjust values from before the write. Read data is registered at the strobe edge and reflects the values from just before that edge. The bench therefore drives strobes just after a falling edge and compares rdata_o at the next falling edge. It compares against a reference model that updates at the same rising edges from the requirement arithmetic. It also checks one hand-computed value for a counted run of exactly ten ticks.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned SEC_W     = 32;
  localparam int unsigned NS_W      = 32;
  localparam int unsigned FRAC_W    = 32;
  localparam int unsigned STEP_NS_W = 4;
  localparam int unsigned ADJ_W     = 32;
  localparam int unsigned NS_PER_S  = 1_000_000_000;
  localparam logic [STEP_NS_W+FRAC_W-1:0] BASE_STEP = 36'hC_8000_0000;

  typedef enum logic [2:0] {
    A_RES  = 3'd0,
    A_NS   = 3'd1,
    A_SEC  = 3'd2,
    A_ADJ  = 3'd3,
    A_CTRL = 3'd4
  } tod_addr_e;
endpackage

// File: rtl/tod_step.sv
module tod_step
  import tod_pkg::*;
#(
  parameter int unsigned P_FRAC_W    = FRAC_W,
  parameter int unsigned P_STEP_NS_W = STEP_NS_W,
  parameter int unsigned P_ADJ_W     = ADJ_W,
  parameter logic [P_STEP_NS_W+P_FRAC_W-1:0] P_BASE = BASE_STEP
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [P_ADJ_W-1:0]     adj_i,
  output logic [P_STEP_NS_W-1:0] step_ns_o,
  output logic [P_FRAC_W-1:0]    step_frac_o
);
  localparam int unsigned STEP_W = P_STEP_NS_W + P_FRAC_W;
  localparam logic [STEP_W-1:0] HALF = STEP_W'(1) << (P_ADJ_W - 1);

  logic [P_ADJ_W-2:0] mag;
  logic [STEP_W-1:0]  step;

  assign mag  = adj_i[P_ADJ_W-2:0];
  // sign-magnitude trim around the nominal period
  assign step = adj_i[P_ADJ_W-1] ? P_BASE - STEP_W'(mag) : P_BASE + STEP_W'(mag);
  assign step_ns_o   = step[STEP_W-1:P_FRAC_W];
  assign step_frac_o = step[P_FRAC_W-1:0];

  // R4 / R5: the step stays strictly within half a nanosecond of nominal
  p_step_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({step_ns_o, step_frac_o} > P_BASE - HALF) && ({step_ns_o, step_frac_o} < P_BASE + HALF));
endmodule

// File: rtl/tod_time.sv
module tod_time
  import tod_pkg::*;
#(
  parameter int unsigned P_SEC_W     = SEC_W,
  parameter int unsigned P_NS_W      = NS_W,
  parameter int unsigned P_FRAC_W    = FRAC_W,
  parameter int unsigned P_STEP_NS_W = STEP_NS_W,
  parameter int unsigned P_NS_PER_S  = NS_PER_S
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic [P_STEP_NS_W-1:0] step_ns_i,
  input  logic [P_FRAC_W-1:0]    step_frac_i,
  input  logic                   load_res_i,
  input  logic                   load_ns_i,
  input  logic                   load_sec_i,
  input  logic [31:0]            wdata_i,
  output logic [P_SEC_W-1:0]     sec_o,
  output logic [P_NS_W-1:0]      ns_o,
  output logic [P_FRAC_W-1:0]    res_o
);
  localparam logic [P_NS_W:0] NS_LIM = (P_NS_W+1)'(P_NS_PER_S);

  logic [P_SEC_W-1:0]  sec_q;
  logic [P_NS_W-1:0]   ns_q;
  logic [P_FRAC_W-1:0] res_q;
  logic [P_FRAC_W:0]   frac_sum;
  logic [P_NS_W:0]     ns_sum;
  logic                roll;
  logic                load_any;
  logic [P_NS_W-1:0]   ns_next;

  assign load_any = load_res_i | load_ns_i | load_sec_i;
  assign frac_sum = {1'b0, res_q} + {1'b0, step_frac_i};
  assign ns_sum   = {1'b0, ns_q} + (P_NS_W+1)'(step_ns_i) + (P_NS_W+1)'(frac_sum[P_FRAC_W]);
  assign roll     = ns_sum >= NS_LIM;
  assign ns_next  = roll ? P_NS_W'(ns_sum - NS_LIM) : ns_sum[P_NS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ns_q  <= '0;
      res_q <= '0;
    end else if (load_any) begin
      // a field write freezes the whole time value for that cycle
      if (load_res_i) res_q <= P_FRAC_W'(wdata_i);
      if (load_ns_i)  ns_q  <= P_NS_W'(wdata_i);
      if (load_sec_i) sec_q <= P_SEC_W'(wdata_i);
    end else if (run_i) begin
      res_q <= frac_sum[P_FRAC_W-1:0];
      ns_q  <= ns_next;
      if (roll) sec_q <= sec_q + 1'b1;
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;
  assign res_o = res_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_any) |=> ($stable(sec_q) && $stable(ns_q) && $stable(res_q)));

  p_ns_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_any && ns_q < P_NS_W'(P_NS_PER_S)) |=> (ns_q < P_NS_W'(P_NS_PER_S)));

  p_sec_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_any) |=> ((sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + 1'b1)));

  p_load_ns_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ns_i && !load_sec_i && !load_res_i) |=>
      (ns_q == P_NS_W'($past(wdata_i)) && $stable(sec_q) && $stable(res_q)));
endmodule

// File: rtl/tod_regif.sv
module tod_regif
  import tod_pkg::*;
#(
  parameter int unsigned P_SEC_W  = SEC_W,
  parameter int unsigned P_NS_W   = NS_W,
  parameter int unsigned P_FRAC_W = FRAC_W,
  parameter int unsigned P_ADJ_W  = ADJ_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [2:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [P_SEC_W-1:0]  sec_i,
  input  logic [P_NS_W-1:0]   ns_i,
  input  logic [P_FRAC_W-1:0] res_i,
  output logic                load_res_o,
  output logic                load_ns_o,
  output logic                load_sec_o,
  output logic [P_ADJ_W-1:0]  adj_o,
  output logic                run_o,
  output logic [31:0]         rdata_o
);
  logic [P_ADJ_W-1:0] adj_q;
  logic               halt_q;
  logic [P_SEC_W-1:0] sh_sec_q;
  logic [P_NS_W-1:0]  sh_ns_q;
  logic [31:0]        rdata_q;
  logic [31:0]        rd_mux;

  assign load_res_o = wr_en_i && addr_i == A_RES;
  assign load_ns_o  = wr_en_i && addr_i == A_NS;
  assign load_sec_o = wr_en_i && addr_i == A_SEC;

  always_comb begin
    case (addr_i)
      A_RES:   rd_mux = 32'(res_i);
      A_NS:    rd_mux = 32'(sh_ns_q);
      A_SEC:   rd_mux = 32'(sh_sec_q);
      A_ADJ:   rd_mux = 32'(adj_q);
      A_CTRL:  rd_mux = {31'd0, halt_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adj_q    <= '0;
      halt_q   <= 1'b1;
      sh_sec_q <= '0;
      sh_ns_q  <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_en_i && addr_i == A_ADJ)  adj_q  <= P_ADJ_W'(wdata_i);
      if (wr_en_i && addr_i == A_CTRL) halt_q <= wdata_i[0];
      if (rd_en_i) begin
        rdata_q <= rd_mux;
        if (addr_i == A_RES) begin
          sh_ns_q  <= ns_i;
          sh_sec_q <= sec_i;
        end
      end
    end
  end

  assign adj_o   = adj_q;
  assign run_o   = !halt_q;
  assign rdata_o = rdata_q;

  p_shadow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_RES) |=> (sh_ns_q == $past(ns_i) && sh_sec_q == $past(sec_i)));

  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  logic [STEP_NS_W-1:0] step_ns;
  logic [FRAC_W-1:0]    step_frac;
  logic [ADJ_W-1:0]     adj;
  logic                 run;
  logic                 load_res, load_ns, load_sec;
  logic [SEC_W-1:0]     sec;
  logic [NS_W-1:0]      ns;
  logic [FRAC_W-1:0]    res;

  tod_regif u_regif (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .sec_i(sec), .ns_i(ns), .res_i(res),
    .load_res_o(load_res), .load_ns_o(load_ns), .load_sec_o(load_sec),
    .adj_o(adj), .run_o(run), .rdata_o
  );

  tod_step u_step (
    .clk_i, .rst_ni, .adj_i(adj), .step_ns_o(step_ns), .step_frac_o(step_frac)
  );

  tod_time u_time (
    .clk_i, .rst_ni, .run_i(run),
    .step_ns_i(step_ns), .step_frac_i(step_frac),
    .load_res_i(load_res), .load_ns_i(load_ns), .load_sec_i(load_sec),
    .wdata_i, .sec_o(sec), .ns_o(ns), .res_o(res)
  );

  p_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wr_en_i) |=> (res != $past(res) || ns != $past(ns)));
endmodule

// File: tb/tb_tod_counter.sv
module tb_tod_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // reference model
  logic [31:0] m_sec, m_ns, m_res, m_adj, m_sh_sec, m_sh_ns, m_rdata;
  logic        m_halt;

  function automatic logic [95:0] f_next(logic [31:0] s, logic [31:0] n,
                                         logic [31:0] r, logic [31:0] a);
    logic [63:0] t, st, lim;
    st = 64'h0000_000C_8000_0000;
    if (a[31]) st = st - 64'(a[30:0]);
    else       st = st + 64'(a[30:0]);
    t   = {n, r} + st;
    lim = 64'd1000000000 << 32;
    if (t >= lim) begin
      t = t - lim;
      s = s + 32'd1;
    end
    return {s, t};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec <= 0; m_ns <= 0; m_res <= 0; m_adj <= 0;
      m_sh_sec <= 0; m_sh_ns <= 0; m_rdata <= 0; m_halt <= 1'b1;
    end else begin
      if (rd) begin
        case (addr)
          3'd0: m_rdata <= m_res;
          3'd1: m_rdata <= m_sh_ns;
          3'd2: m_rdata <= m_sh_sec;
          3'd3: m_rdata <= m_adj;
          3'd4: m_rdata <= {31'd0, m_halt};
          default: m_rdata <= 0;
        endcase
        if (addr == 3'd0) begin
          m_sh_ns <= m_ns; m_sh_sec <= m_sec;
        end
      end
      if (wr && addr <= 3'd2) begin
        if (addr == 3'd0) m_res <= wdata;
        if (addr == 3'd1) m_ns  <= wdata;
        if (addr == 3'd2) m_sec <= wdata;
      end else if (!m_halt) begin
        {m_sec, m_ns, m_res} <= f_next(m_sec, m_ns, m_res, m_adj);
      end
      if (wr && addr == 3'd3) m_adj  <= wdata;
      if (wr && addr == 3'd4) m_halt <= wdata[0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // tasks start and end on a falling edge
  task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, input string req);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    chk(req, rdata, m_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_time(input string req);
    do_rd(3'd0, req);
    do_rd(3'd1, req);
    do_rd(3'd2, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R10 control reset and unused addresses
    for (int a = 0; a < 8; a++) do_rd(3'(a), "R1");
    do_rd(3'd4, "R10");
    chk("R1", rdata, 32'd1);

    // R2 halted counter holds
    idle(20);
    do_rd(3'd0, "R2");
    chk("R2", rdata, 32'd0);

    // R3 hand-computed: 10 ticks from zero with no trim
    do_wr(3'd4, 32'd0);
    idle(9);
    do_wr(3'd4, 32'd1);
    do_rd(3'd0, "R3");
    chk("R3", rdata, 32'd0);
    do_rd(3'd1, "R3");
    chk("R3", rdata, 32'd125);

    // R4 positive trim at maximum
    do_wr(3'd3, 32'h7FFF_FFFF);
    do_wr(3'd4, 32'd0);
    idle(37);
    read_time("R4");
    // R5 negative trim at maximum and a small one
    do_wr(3'd3, 32'hFFFF_FFFF);
    idle(23);
    read_time("R5");
    do_wr(3'd3, 32'h8000_0005);
    idle(11);
    read_time("R5");

    // R6 nanosecond rollover
    do_wr(3'd4, 32'd1);
    do_wr(3'd1, 32'd999_999_990);
    do_wr(3'd2, 32'd41);
    do_wr(3'd4, 32'd0);
    idle(1);
    read_time("R6");
    idle(3);
    read_time("R6");

    // R7 seconds wrap
    do_wr(3'd4, 32'd1);
    do_wr(3'd2, 32'hFFFF_FFFF);
    do_wr(3'd1, 32'd999_999_995);
    do_wr(3'd4, 32'd0);
    idle(2);
    read_time("R7");

    // R8 shadow keeps snapshot while time runs on
    do_rd(3'd0, "R8");
    idle(50);
    do_rd(3'd1, "R8");
    do_rd(3'd2, "R8");
    idle(5);
    do_rd(3'd1, "R8");

    // R9 write freezes time for that cycle
    do_wr(3'd0, 32'h1234_5678);
    do_wr(3'd1, 32'd500);
    read_time("R9");

    // R10 writes to unused addresses ignored
    do_wr(3'd5, 32'hFFFF_FFFF);
    do_wr(3'd7, 32'hFFFF_FFFF);
    do_rd(3'd3, "R10");
    do_rd(3'd4, "R10");
    do_rd(3'd6, "R10");
    read_time("R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) begin
        idle(1);
      end else if (op < 7) begin
        logic [2:0] a;
        logic [31:0] d;
        a = 3'($urandom_range(0, 7));
        d = $urandom;
        if (a == 3'd1) d = $urandom_range(0, 999_999_999);
        if (a == 3'd2 && $urandom_range(0, 3) == 0) d = 32'hFFFF_FFFF;
        if (a == 3'd4) d = {31'd0, ($urandom_range(0, 4) == 0)};
        do_wr(a, d);
      end else begin
        do_rd(3'($urandom_range(0, 7)), "R8");
      end
    end
    read_time("R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule